// File: doc/BRIEF.md
# Modulo loop branch controller

This block holds the loop-control state of a software-pipelined loop engine: a loop counter, an epilogue counter, a file of 64 one-bit stage predicates whose upper 48 entries rotate, and one rotation base for each rotating register region. Each time the pipeline reaches the loop's closing branch it pulses a branch strobe. The block then decides whether the branch is taken, counts down the proper counter, writes a fresh stage predicate and ages every rotating value by one position. Stage 1 of the loop body is guarded by virtual predicate p16, stage 2 by p17 and so on. While iterations remain, a 1 enters the pipeline. Once the loop count is spent, zeros enter instead and the epilogue count drains the stages still in flight.

Software sets up a loop through a small command port: loop count, epilogue count, the 48 rotating predicates, the 15 writable fixed predicates, and the sizes of the general and floating-point rotating regions. The operand stage reads predicates through combinational read ports. It turns virtual register numbers into physical ones through two rename ports, one per register file. In each file registers 32 and up rotate inside a region whose size is programmed. A size of zero turns rotation off for that file.

Top module: `mloop_ctrl`

## Requirements
- R1: After reset the loop and epilogue counts are 0, every predicate reads 0 except p0, which reads 1, both rename ports return their input unchanged, and br_done is 0.
- R2: A branch with loop count above zero is taken, decrements the loop count, leaves the epilogue count alone, rotates, and writes 1 into the new p16. The loop count is loaded with command select 0 from cmd_data[15:0].
- R3: A branch with loop count zero and epilogue count above one is taken, decrements the epilogue count, rotates and writes 0 into the new p16. The epilogue count is loaded with command select 1 from cmd_data[5:0].
- R4: A branch with loop count zero and epilogue count one is not taken, sets the epilogue count to 0, rotates and writes 0 into the new p16. With both counts zero a branch is not taken and changes nothing.
- R5: A rotation moves the value of virtual p(n) to p(n+1) for n from 16 to 62, and the old p63 slot becomes the new p16. p0 to p15 never move.
- R6: p0 always reads 1. Command select 3 writes p1 to p15 from cmd_data[15:1], and cmd_data[0] is ignored.
- R7: Command select 2 loads p16+i from cmd_data[i] for i from 0 to 47 and sets the predicate rotation base to 0.
- R8: General-register rename: a virtual index v with 32 <= v < 32+size maps to 32 + ((v-32+base) mod size), and any other index is returned unchanged. Each rotating branch lowers the base by one modulo size. Command select 4 writes the size from cmd_data[6:0], which is clamped to 96 and rounded down to a multiple of 8, and it also clears the base.
- R9: The floating-point rename follows the same rule with command select 5 and no rounding. A size of 0 leaves every index unchanged.
- R10: br_done and br_taken are registered. They are valid in the cycle after the branch strobe. Counter, predicate and base updates take effect at that same edge, and predicate reads and renames are combinational.
- R11: When a command and a branch strobe arrive in the same cycle, the command is applied and the branch is dropped. br_done stays 0 and nothing rotates.
- R12: With loop count 127, epilogue count 4 and only p16 set, the loop runs 131 branches of which 130 are taken. Before the branches, p16 is 1 128 times and p19 is 1 128 times, and p19 is first 1 three branches after p16 is first 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | 3 | Command select: 0 loop count, 1 epilogue count, 2 rotating predicates, 3 fixed predicates, 4 general size, 5 floating-point size |
| cmd_data | input | 64 | Command payload |
| br_req | input | 1 | Loop branch strobe |
| br_done | output | 1 | Branch result valid, one cycle after br_req |
| br_taken | output | 1 | Branch taken, valid with br_done |
| pr_rd_idx | input | 12 | Two 6-bit virtual predicate indices, port k at bits 6k+5:6k |
| pr_rd_val | output | 2 | Predicate values for the two read ports |
| gr_vidx | input | 7 | Virtual general register index |
| gr_pidx | output | 7 | Physical general register index |
| fr_vidx | input | 7 | Virtual floating-point register index |
| fr_pidx | output | 7 | Physical floating-point register index |

## Verification
The branch result appears one clock after the strobe. The bench raises br_req on a falling edge, drops it on the next falling edge and samples br_done and br_taken there, half a cycle after the edge that registered them. Counters, predicates and rotation bases change at that same edge, so predicate reads and renames are sampled after that falling edge with a short settling delay, because those paths are combinational. Commands take effect at the first rising edge after the strobe and are checked from the following falling edge onward.

// File: rtl/mloop_pkg.sv
`timescale 1ns/1ps
package mloop_pkg;

  typedef enum logic [2:0] {
    CMD_LC   = 3'd0,
    CMD_EC   = 3'd1,
    CMD_PHI  = 3'd2,
    CMD_PLO  = 3'd3,
    CMD_GSZ  = 3'd4,
    CMD_FSZ  = 3'd5
  } cmd_sel_e;

  typedef struct packed {
    logic rotate;
    logic inject;
    logic taken;
  } br_outcome_t;

  localparam int PRED_TOTAL = 64;
  localparam int PRED_FIXED = 16;
  localparam int REG_TOTAL  = 128;
  localparam int REG_FIXED  = 32;

endpackage

// File: rtl/mloop_count.sv
`timescale 1ns/1ps
module mloop_count
  import mloop_pkg::*;
#(
  parameter int LC_W = 16,
  parameter int EC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_lc,
  input  logic            ld_ec,
  input  logic [LC_W-1:0] lc_in,
  input  logic [EC_W-1:0] ec_in,
  input  logic            step,
  output br_outcome_t     outc
);

  logic [LC_W-1:0] lc_q, lc_d;
  logic [EC_W-1:0] ec_q, ec_d;

  // Decision depends only on current counter state
  always_comb begin
    outc = '0;
    if (lc_q != '0) begin
      outc.taken  = 1'b1;
      outc.rotate = 1'b1;
      outc.inject = 1'b1;
    end else if (ec_q > EC_W'(1)) begin
      outc.taken  = 1'b1;
      outc.rotate = 1'b1;
    end else if (ec_q == EC_W'(1)) begin
      outc.rotate = 1'b1;
    end
  end

  always_comb begin
    lc_d = lc_q;
    ec_d = ec_q;
    if (ld_lc)                    lc_d = lc_in;
    else if (step && lc_q != '0)  lc_d = lc_q - 1'b1;
    if (ld_ec)                                   ec_d = ec_in;
    else if (step && lc_q == '0 && ec_q != '0)   ec_d = ec_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0;
      ec_q <= '0;
    end else begin
      lc_q <= lc_d;
      ec_q <= ec_d;
    end
  end

  assert_lc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_lc && lc_q != '0) |=> (lc_q == $past(lc_q) - 1'b1));

  assert_ec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_ec && lc_q != '0) |=> (ec_q == $past(ec_q)));

  assert_ec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_ec && lc_q == '0 && ec_q != '0) |=> (ec_q == $past(ec_q) - 1'b1));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_lc && !ld_ec && lc_q == '0 && ec_q == '0) |=> (lc_q == '0 && ec_q == '0));

endmodule

// File: rtl/mloop_pred.sv
`timescale 1ns/1ps
module mloop_pred #(
  parameter int NP   = 64,
  parameter int NFIX = 16,
  parameter int NRD  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_hi,
  input  logic [NP-NFIX-1:0]           hi_in,
  input  logic                         ld_lo,
  input  logic [NFIX-1:0]              lo_in,
  input  logic                         rotate,
  input  logic                         inject,
  input  logic [NRD*$clog2(NP)-1:0]    rd_idx,
  output logic [NRD-1:0]               rd_val
);

  localparam int NROT = NP - NFIX;
  localparam int IW   = $clog2(NP);
  localparam int BW   = $clog2(NROT);
  localparam int LW   = $clog2(NFIX);

  logic [NFIX-1:1] lo_q, lo_d;
  logic [NROT-1:0] hi_q, hi_d;
  logic [BW-1:0]   base_q, base_d, base_nx;
  logic            unused_p0;

  assign unused_p0 = lo_in[0];

  function automatic logic [BW-1:0] slot_of(input logic [BW-1:0] o,
                                            input logic [BW-1:0] b);
    logic [BW:0] s;
    s = {1'b0, o} + {1'b0, b};
    if (s >= (BW+1)'(NROT)) s = s - (BW+1)'(NROT);
    return s[BW-1:0];
  endfunction

  // Rotation lowers the base; the slot it lands on becomes virtual p16
  assign base_nx = (base_q == '0) ? BW'(NROT - 1) : base_q - 1'b1;

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    lo_d   = lo_q;
    if (ld_hi) begin
      hi_d   = hi_in;
      base_d = '0;
    end else if (rotate) begin
      base_d          = base_nx;
      hi_d[base_nx]   = inject;
    end
    if (ld_lo) lo_d = lo_in[NFIX-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      base_q <= '0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      base_q <= base_d;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    logic [IW-1:0] idx;
    logic [BW-1:0] off;
    logic          val;
    assign idx = rd_idx[k*IW +: IW];
    assign off = BW'(idx - IW'(NFIX));
    always_comb begin
      if (idx == '0)                val = 1'b1;
      else if (idx < IW'(NFIX))     val = lo_q[idx[LW-1:0]];
      else                          val = hi_q[slot_of(off, base_q)];
    end
    assign rd_val[k] = val;
  end

  assert_base_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    base_q < BW'(NROT));

  assert_inject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !ld_hi) |=> (hi_q[base_q] == $past(inject)));

  assert_mask_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> (base_q == '0));

endmodule

// File: rtl/mloop_rename.sv
`timescale 1ns/1ps
module mloop_rename #(
  parameter int NREG  = 128,
  parameter int NFIX  = 32,
  parameter int ALIGN = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_size,
  input  logic [$clog2(NREG-NFIX+1)-1:0] size_in,
  input  logic                      rotate,
  input  logic [$clog2(NREG)-1:0]   vidx,
  output logic [$clog2(NREG)-1:0]   pidx
);

  localparam int NROT = NREG - NFIX;
  localparam int IW   = $clog2(NREG);
  localparam int SW   = $clog2(NROT + 1);

  logic [SW-1:0] size_q, size_d, base_q, base_d;
  logic [SW-1:0] size_lim, size_al, rel;
  logic [SW:0]   sum;
  logic          in_rgn;

  assign size_lim = (size_in > SW'(NROT)) ? SW'(NROT) : size_in;
  assign size_al  = size_lim & ~SW'(ALIGN - 1);

  always_comb begin
    size_d = size_q;
    base_d = base_q;
    if (ld_size) begin
      size_d = size_al;
      base_d = '0;
    end else if (rotate && size_q != '0) begin
      base_d = (base_q == '0) ? size_q - 1'b1 : base_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      base_q <= '0;
    end else begin
      size_q <= size_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    rel    = SW'(vidx - IW'(NFIX));
    in_rgn = (vidx >= IW'(NFIX)) && (rel < size_q);
    sum    = {1'b0, rel} + {1'b0, base_q};
    if (sum >= {1'b0, size_q}) sum = sum - {1'b0, size_q};
    pidx   = in_rgn ? (IW'(NFIX) + IW'(sum)) : vidx;
  end

  assert_base_lt_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q != '0) |-> (base_q < size_q));

  assert_pidx_in_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_rgn |-> (pidx >= IW'(NFIX) && ({1'b0, pidx} < (IW+1)'(NFIX) + (IW+1)'(size_q))));

  assert_outside_identity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == '0) |-> (pidx == vidx));

endmodule

// File: rtl/mloop_ctrl.sv
`timescale 1ns/1ps
module mloop_ctrl
  import mloop_pkg::*;
#(
  parameter int LC_W   = 16,
  parameter int EC_W   = 6,
  parameter int DATA_W = 64,
  parameter int NRD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_sel,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              br_req,
  output logic              br_done,
  output logic              br_taken,
  input  logic [NRD*6-1:0]  pr_rd_idx,
  output logic [NRD-1:0]    pr_rd_val,
  input  logic [6:0]        gr_vidx,
  output logic [6:0]        gr_pidx,
  input  logic [6:0]        fr_vidx,
  output logic [6:0]        fr_pidx
);

  localparam int NROTP = PRED_TOTAL - PRED_FIXED;
  localparam int SW    = $clog2(REG_TOTAL - REG_FIXED + 1);

  br_outcome_t outc;
  logic        step, rot;
  logic        done_q, taken_q;
  logic        unused_hi;
  logic [1:0]  ld_sz;
  logic [1:0][6:0] vidx_a, pidx_a;

  assign unused_hi = ^cmd_data[DATA_W-1:NROTP];

  // A command in the same cycle drops the branch
  assign step = br_req && !cmd_valid;
  assign rot  = step && outc.rotate;

  mloop_count #(.LC_W(LC_W), .EC_W(EC_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lc (cmd_valid && cmd_sel == CMD_LC),
    .ld_ec (cmd_valid && cmd_sel == CMD_EC),
    .lc_in (cmd_data[LC_W-1:0]),
    .ec_in (cmd_data[EC_W-1:0]),
    .step  (step),
    .outc  (outc)
  );

  mloop_pred #(.NP(PRED_TOTAL), .NFIX(PRED_FIXED), .NRD(NRD)) u_pred (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_hi  (cmd_valid && cmd_sel == CMD_PHI),
    .hi_in  (cmd_data[NROTP-1:0]),
    .ld_lo  (cmd_valid && cmd_sel == CMD_PLO),
    .lo_in  (cmd_data[PRED_FIXED-1:0]),
    .rotate (rot),
    .inject (outc.inject),
    .rd_idx (pr_rd_idx),
    .rd_val (pr_rd_val)
  );

  assign ld_sz[0]  = cmd_valid && cmd_sel == CMD_GSZ;
  assign ld_sz[1]  = cmd_valid && cmd_sel == CMD_FSZ;
  assign vidx_a[0] = gr_vidx;
  assign vidx_a[1] = fr_vidx;
  assign gr_pidx   = pidx_a[0];
  assign fr_pidx   = pidx_a[1];

  // File 0 (general) rotates in groups of 8, file 1 (floating point) freely
  for (genvar g = 0; g < 2; g++) begin : g_ren
    mloop_rename #(.NREG(REG_TOTAL), .NFIX(REG_FIXED), .ALIGN(g == 0 ? 8 : 1)) u_ren (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_size (ld_sz[g]),
      .size_in (cmd_data[SW-1:0]),
      .rotate  (rot),
      .vidx    (vidx_a[g]),
      .pidx    (pidx_a[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      done_q  <= step;
      taken_q <= step && outc.taken;
    end
  end

  assign br_done  = done_q;
  assign br_taken = taken_q;

  assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |-> $past(br_req && !cmd_valid));

  assert_taken_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_done);

  assert_cmd_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && cmd_valid) |=> !br_done);

  assert_p0_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_rd_idx[5:0] == 6'd0) |-> pr_rd_val[0]);

endmodule

// File: tb/mloop_ctrl_tb.sv
`timescale 1ns/1ps
module mloop_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_sel;
  logic [63:0] cmd_data;
  logic        br_req;
  logic        br_done, br_taken;
  logic [11:0] pr_rd_idx;
  logic [1:0]  pr_rd_val;
  logic [6:0]  gr_vidx, gr_pidx, fr_vidx, fr_pidx;

  int nchk  = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  mloop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .br_req(br_req), .br_done(br_done), .br_taken(br_taken),
    .pr_rd_idx(pr_rd_idx), .pr_rd_val(pr_rd_val), .gr_vidx(gr_vidx),
    .gr_pidx(gr_pidx), .fr_vidx(fr_vidx), .fr_pidx(fr_pidx)
  );

  // {taken, p19, p18, p17, p16} after each branch: LC=2, EC=3, only p16 set
  localparam logic [4:0] VEC [6] = '{5'b10011, 5'b10111, 5'b11110,
                                     5'b11100, 5'b01000, 5'b01000};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data = '0;
  endtask

  task automatic do_br(output logic done, output logic taken);
    @(negedge clk);
    br_req = 1'b1;
    @(negedge clk);
    br_req = 1'b0;
    done = br_done; taken = br_taken;
  endtask

  task automatic rd_p(input int idx, output logic v);
    pr_rd_idx[5:0] = 6'(idx);
    #1;
    v = pr_rd_val[0];
  endtask

  task automatic ren(input int gv, input int fv, output logic [6:0] gp, output logic [6:0] fp);
    gr_vidx = 7'(gv); fr_vidx = 7'(fv);
    #1;
    gp = gr_pidx; fp = fr_pidx;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic v, d, t;
    logic [6:0] gp, fp;
    int loads, stores, nbr, ntaken, first_ld, first_st;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_sel = '0; cmd_data = '0;
    br_req = 1'b0; pr_rd_idx = '0; gr_vidx = '0; fr_vidx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 br_done", br_done, 0);
    rd_p(0, v);  chk("R1 p0", v, 1);
    rd_p(5, v);  chk("R1 p5", v, 0);
    rd_p(16, v); chk("R1 p16", v, 0);
    rd_p(40, v); chk("R1 p40", v, 0);
    ren(40, 33, gp, fp);
    chk("R1 gr identity", gp, 40);
    chk("R1 fr identity", fp, 33);
    do_br(d, t);
    chk("R1 idle branch not taken", t, 0);

    // R6 fixed predicates, p0 ignores writes
    do_cmd(3'd3, 64'h0021);
    pr_rd_idx = {6'd5, 6'd0}; #1;
    chk("R6 p0 after write 1", pr_rd_val[0], 1);
    chk("R6 p5 set via port 1", pr_rd_val[1], 1);
    rd_p(1, v); chk("R6 p1 clear", v, 0);
    do_cmd(3'd3, 64'h0000);
    rd_p(0, v); chk("R6 p0 ignores write 0", v, 1);
    rd_p(5, v); chk("R6 p5 cleared", v, 0);
    do_cmd(3'd3, 64'h0020);

    // R2 R3 R4 R5 R10: vector table walk
    do_cmd(3'd2, 64'h1);
    do_cmd(3'd0, 64'd2);
    do_cmd(3'd1, 64'd3);
    for (int i = 0; i < 6; i++) begin
      do_br(d, t);
      chk($sformatf("R10 done vec %0d", i), d, 1);
      chk($sformatf("R2/R3/R4 taken vec %0d", i), t, VEC[i][4]);
      for (int j = 0; j < 4; j++) begin
        rd_p(16 + j, v);
        chk($sformatf("R5 vec %0d p%0d", i, 16 + j), v, VEC[i][j]);
      end
    end
    rd_p(5, v); chk("R5 p5 never rotates", v, 1);

    // R7 mask load resets base; R4/R5 final epilogue branch and p62->p63
    do_cmd(3'd2, 64'h4000_0000_0000);
    rd_p(62, v); chk("R7 p62 loaded", v, 1);
    rd_p(63, v); chk("R7 p63 clear", v, 0);
    rd_p(17, v); chk("R7 p17 after base reset", v, 0);
    do_cmd(3'd1, 64'd1);
    do_br(d, t);
    chk("R4 ec=1 not taken", t, 0);
    chk("R4 ec=1 done", d, 1);
    rd_p(63, v); chk("R5 p62 aged to p63", v, 1);
    rd_p(62, v); chk("R5 p61 aged to p62", v, 0);
    rd_p(16, v); chk("R4 zero injected", v, 0);

    // R11 command and branch together
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = 3'd1; cmd_data = 64'd3; br_req = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; br_req = 1'b0; cmd_data = '0;
    chk("R11 branch dropped", br_done, 0);
    rd_p(63, v); chk("R11 no rotation", v, 1);

    // R8 R9 renaming
    do_cmd(3'd4, 64'd13);
    do_cmd(3'd5, 64'd10);
    ren(33, 41, gp, fp);
    chk("R8 gr in region base 0", gp, 33);
    chk("R9 fr in region base 0", fp, 41);
    ren(40, 42, gp, fp);
    chk("R8 gr size rounded to 8", gp, 40);
    chk("R9 fr outside region", fp, 42);
    do_br(d, t);
    chk("R11 command was applied", t, 1);
    ren(32, 32, gp, fp);
    chk("R8 gr 32 after one rotation", gp, 39);
    chk("R9 fr 32 after one rotation", fp, 41);
    ren(33, 33, gp, fp);
    chk("R8 gr 33 wraps", gp, 32);
    chk("R9 fr 33 wraps", fp, 32);
    ren(5, 5, gp, fp);
    chk("R8 gr fixed reg", gp, 5);
    do_br(d, t);
    do_br(d, t);
    ren(32, 32, gp, fp);
    chk("R8 gr 32 after three rotations", gp, 37);
    chk("R9 fr 32 after three rotations", fp, 39);
    do_cmd(3'd4, 64'd127);
    ren(127, 32, gp, fp);
    chk("R8 gr size clamped to 96", gp, 127);
    do_cmd(3'd5, 64'd0);
    ren(32, 50, gp, fp);
    chk("R9 fr size 0 identity", fp, 50);

    // R12 full pipelined loop
    do_cmd(3'd2, 64'h1);
    do_cmd(3'd0, 64'd127);
    do_cmd(3'd1, 64'd4);
    loads = 0; stores = 0; nbr = 0; ntaken = 0; first_ld = -1; first_st = -1;
    for (int i = 0; i < 200; i++) begin
      rd_p(16, v);
      if (v) begin loads++; if (first_ld < 0) first_ld = i; end
      rd_p(19, v);
      if (v) begin stores++; if (first_st < 0) first_st = i; end
      do_br(d, t);
      nbr++;
      if (t) ntaken++;
      else break;
    end
    chk("R12 branches", nbr, 131);
    chk("R12 taken", ntaken, 130);
    chk("R12 stage-1 count", loads, 128);
    chk("R12 stage-4 count", stores, 128);
    chk("R12 skew", first_st - first_ld, 3);

    finish_run();
  end

endmodule